// File: doc/BRIEF.md
# PCI Interrupt Slot Router

This block takes interrupt level-change events from devices on a PCI bus and turns them into a single interrupt request toward the CPU. Each event names the slot the device sits in and which of its four interrupt pins changed. The block first decides which internal interrupt line that slot and pin belong to. Some slots share a fixed line. Some slots rotate their pins across a window of lines, so devices in neighbouring slots do not all pile onto the same line.

The resolved line number is reported one clock after the event, together with a valid strobe. Lines reached through the routing table carry a base offset of 32. The chosen line then indexes two 32-bit configuration words, an edge word and a polarity word, and these decide how the CPU output reacts:

- An edge-configured line gives a one-clock pulse. After the pulse the output drops back to the level it held before.
- A level-configured line drives and holds the output at its polarity bit.

Top module: `pci_irq_router`

## Requirements
- R1: After reset, `cpu_irq` is 0, `irq_line_vld` is 0 and `irq_line` is 0.
- R2: An event from slot 5 on pin n (0..3) reports line 32 + n and uses configuration index n.
- R3: An event from slot 6 reports line 36 (index 4), and one from slot 7 reports line 37 (index 5), for every pin.
- R4: An event from slot s in 8..12 on pin n reports line 32 + 6 + (s - 8) + n and uses index 6 + (s - 8) + n.
- R5: An event from any other slot reports the raw pin number n as the line, with no offset, and uses index n.
- R6: `irq_line` and `irq_line_vld` are registered: they appear exactly one clock after the cycle in which `evt_valid` is high, and `irq_line_vld` is low in every other cycle.
- R7: When bit index of `edge_cfg` is 1, `cpu_irq` is 1 in the cycle after the event and returns, one cycle later, to the level held before the pulse.
- R8: When bit index of `edge_cfg` is 0, `cpu_irq` takes the value of bit index of `pol_cfg` in the cycle after the event.
- R9: An edge event leaves the held level unchanged. A held high level stays high through and after a pulse, and a held low level is low again after it.
- R10: Without an event, `cpu_irq` keeps its held value indefinitely, whatever the configuration inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | An interrupt level-change event is present this cycle |
| evt_slot | input | 5 | Slot number of the signalling device |
| evt_pin | input | 2 | Interrupt pin index (0..3) of the device |
| edge_cfg | input | 32 | Edge-mode bit per internal line index |
| pol_cfg | input | 32 | Polarity bit per internal line index |
| irq_line | output | 6 | Resolved line number (offset 32 for routed slots) |
| irq_line_vld | output | 1 | `irq_line` carries a new result |
| cpu_irq | output | 1 | Interrupt request toward the CPU |

## Verification
Suppose the stored held level were wrong, for example overwritten by a pulse. It would show on `cpu_irq` one clock after the pulse cycle, as a level that differs from the one set by the last level event. The checks right after each pulse and over idle stretches catch this within two cycles. Suppose instead the routing picked the wrong index. Then `irq_line` would differ one clock after the event, and `cpu_irq` would follow the wrong edge or polarity bit in that same cycle. The bench therefore loads edge and polarity words with bits that differ between neighbouring indexes.

// File: rtl/pir_pkg.sv
package pir_pkg;
  localparam int unsigned PIR_SLOT_W    = 5;
  localparam int unsigned PIR_PIN_W     = 2;
  localparam int unsigned PIR_CFG_W     = 32;
  localparam int unsigned PIR_LINE_W    = 6;
  localparam int unsigned PIR_IRQ_BASE  = 32;
  localparam int unsigned PIR_QUAD_SLOT = 5;
  localparam int unsigned PIR_FIXA_SLOT = 6;
  localparam int unsigned PIR_FIXB_SLOT = 7;
  localparam int unsigned PIR_FIXA_LINE = 4;
  localparam int unsigned PIR_FIXB_LINE = 5;
  localparam int unsigned PIR_SWZ_LO    = 8;
  localparam int unsigned PIR_SWZ_HI    = 12;
  localparam int unsigned PIR_SWZ_OFS   = 6;

  typedef enum logic [1:0] {
    ROUTE_QUAD = 2'd0,
    ROUTE_FIX  = 2'd1,
    ROUTE_SWZ  = 2'd2,
    ROUTE_PASS = 2'd3
  } route_kind_e;
endpackage

// File: rtl/pir_slot_map.sv
module pir_slot_map
  import pir_pkg::*;
#(
  parameter int unsigned SLOT_W    = PIR_SLOT_W,
  parameter int unsigned PIN_W     = PIR_PIN_W,
  parameter int unsigned LINE_W    = PIR_LINE_W,
  parameter int unsigned IRQ_BASE  = PIR_IRQ_BASE,
  parameter int unsigned QUAD_SLOT = PIR_QUAD_SLOT,
  parameter int unsigned FIXA_SLOT = PIR_FIXA_SLOT,
  parameter int unsigned FIXB_SLOT = PIR_FIXB_SLOT,
  parameter int unsigned FIXA_LINE = PIR_FIXA_LINE,
  parameter int unsigned FIXB_LINE = PIR_FIXB_LINE,
  parameter int unsigned SWZ_LO    = PIR_SWZ_LO,
  parameter int unsigned SWZ_HI    = PIR_SWZ_HI,
  parameter int unsigned SWZ_OFS   = PIR_SWZ_OFS
) (
  input  logic [SLOT_W-1:0] slot,
  input  logic [PIN_W-1:0]  pin,
  output logic [LINE_W-1:0] cfg_idx,
  output logic [LINE_W-1:0] ext_line
);
  localparam logic [SLOT_W-1:0] S_QUAD = SLOT_W'(QUAD_SLOT);
  localparam logic [SLOT_W-1:0] S_FIXA = SLOT_W'(FIXA_SLOT);
  localparam logic [SLOT_W-1:0] S_FIXB = SLOT_W'(FIXB_SLOT);
  localparam logic [SLOT_W-1:0] S_SWLO = SLOT_W'(SWZ_LO);
  localparam logic [SLOT_W-1:0] S_SWHI = SLOT_W'(SWZ_HI);

  route_kind_e       kind;
  logic [LINE_W-1:0] pin_ext;
  logic [LINE_W-1:0] slot_ext;

  assign pin_ext  = LINE_W'(pin);
  assign slot_ext = LINE_W'(slot);

  // classify the slot
  always_comb begin
    if (slot == S_QUAD)                         kind = ROUTE_QUAD;
    else if (slot == S_FIXA || slot == S_FIXB)  kind = ROUTE_FIX;
    else if (slot >= S_SWLO && slot <= S_SWHI)  kind = ROUTE_SWZ;
    else                                        kind = ROUTE_PASS;
  end

  // resolve the internal index and the presented number
  always_comb begin
    cfg_idx  = pin_ext;
    ext_line = pin_ext;
    unique case (kind)
      ROUTE_QUAD: begin
        cfg_idx  = LINE_W'(pin_ext % LINE_W'(4));
        ext_line = cfg_idx + LINE_W'(IRQ_BASE);
      end
      ROUTE_FIX: begin
        cfg_idx  = (slot == S_FIXA) ? LINE_W'(FIXA_LINE) : LINE_W'(FIXB_LINE);
        ext_line = cfg_idx + LINE_W'(IRQ_BASE);
      end
      ROUTE_SWZ: begin
        cfg_idx  = slot_ext - LINE_W'(SWZ_LO) + pin_ext + LINE_W'(SWZ_OFS);
        ext_line = cfg_idx + LINE_W'(IRQ_BASE);
      end
      ROUTE_PASS: begin
        cfg_idx  = pin_ext;
        ext_line = pin_ext;
      end
      default: begin
        cfg_idx  = pin_ext;
        ext_line = pin_ext;
      end
    endcase
  end
endmodule

// File: rtl/pir_cpu_drive.sv
module pir_cpu_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic ev,
  input  logic edge_bit,
  input  logic pol_bit,
  output logic cpu_irq
);
  logic hold_q, hold_d;
  logic irq_q, irq_d;
  logic hold_en;

  assign hold_en = ev & ~edge_bit;

  always_comb begin
    hold_d = hold_q;
    irq_d  = hold_q;
    if (ev) begin
      if (edge_bit) begin
        irq_d = 1'b1;
      end else begin
        hold_d = pol_bit;
        irq_d  = pol_bit;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
    end else if (hold_en) begin
      hold_q <= hold_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign cpu_irq = irq_q;
endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router
  import pir_pkg::*;
#(
  parameter int unsigned SLOT_W   = PIR_SLOT_W,
  parameter int unsigned PIN_W    = PIR_PIN_W,
  parameter int unsigned CFG_W    = PIR_CFG_W,
  parameter int unsigned LINE_W   = PIR_LINE_W,
  parameter int unsigned IRQ_BASE = PIR_IRQ_BASE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic [SLOT_W-1:0] evt_slot,
  input  logic [PIN_W-1:0]  evt_pin,
  input  logic [CFG_W-1:0]  edge_cfg,
  input  logic [CFG_W-1:0]  pol_cfg,
  output logic [LINE_W-1:0] irq_line,
  output logic              irq_line_vld,
  output logic              cpu_irq
);
  localparam int unsigned CFG_IW = $clog2(CFG_W);

  logic [LINE_W-1:0] map_idx;
  logic [LINE_W-1:0] map_line;
  logic              sel_edge;
  logic              sel_pol;
  logic [LINE_W-1:0] line_q, line_d;
  logic              vld_q, vld_d;

  pir_slot_map #(
    .SLOT_W   (SLOT_W),
    .PIN_W    (PIN_W),
    .LINE_W   (LINE_W),
    .IRQ_BASE (IRQ_BASE)
  ) u_map (
    .slot     (evt_slot),
    .pin      (evt_pin),
    .cfg_idx  (map_idx),
    .ext_line (map_line)
  );

  assign sel_edge = edge_cfg[map_idx[CFG_IW-1:0]];
  assign sel_pol  = pol_cfg[map_idx[CFG_IW-1:0]];

  pir_cpu_drive u_drive (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev       (evt_valid),
    .edge_bit (sel_edge),
    .pol_bit  (sel_pol),
    .cpu_irq  (cpu_irq)
  );

  always_comb begin
    line_d = line_q;
    vld_d  = evt_valid;
    if (evt_valid) line_d = map_line;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      line_q <= line_d;
      vld_q  <= vld_d;
    end
  end

  assign irq_line     = line_q;
  assign irq_line_vld = vld_q;
endmodule

// File: rtl/pir_checker.sv
module pir_checker #(
  parameter int unsigned LINE_W   = 6,
  parameter int unsigned IRQ_BASE = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evt_valid,
  input logic              sel_edge,
  input logic              sel_pol,
  input logic [LINE_W-1:0] irq_line,
  input logic              irq_line_vld,
  input logic              cpu_irq
);
  AST_VLD_FOLLOWS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> irq_line_vld); // R6

  AST_VLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_valid |=> !irq_line_vld); // R6

  AST_EDGE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && sel_edge) |=> cpu_irq); // R7

  AST_LEVEL_POL: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !sel_edge) |=> (cpu_irq == $past(sel_pol))); // R8

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_valid && !$past(evt_valid)) |=> $stable(cpu_irq)); // R10

  AST_LINE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_line_vld |-> ((irq_line >= LINE_W'(IRQ_BASE)) || (irq_line < LINE_W'(4)))); // R5
endmodule

bind pci_irq_router pir_checker #(
  .LINE_W   (LINE_W),
  .IRQ_BASE (IRQ_BASE)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .evt_valid    (evt_valid),
  .sel_edge     (sel_edge),
  .sel_pol      (sel_pol),
  .irq_line     (irq_line),
  .irq_line_vld (irq_line_vld),
  .cpu_irq      (cpu_irq)
);

// File: tb/tb_pci_irq_router.sv
module tb_pci_irq_router;
  logic        clk;
  logic        rst_n;
  logic        evt_valid;
  logic [4:0]  evt_slot;
  logic [1:0]  evt_pin;
  logic [31:0] edge_cfg;
  logic [31:0] pol_cfg;
  logic [5:0]  irq_line;
  logic        irq_line_vld;
  logic        cpu_irq;

  int checks = 0;
  int errors = 0;
  bit held   = 1'b0;

  typedef struct {
    int    line;
    bit    now;
    bit    after;
    string tag;
  } exp_t;
  exp_t sb[$];

  bit    after_pend = 0;
  bit    after_val;
  string after_tag;

  pci_irq_router dut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_slot(evt_slot),
    .evt_pin(evt_pin), .edge_cfg(edge_cfg), .pol_cfg(pol_cfg),
    .irq_line(irq_line), .irq_line_vld(irq_line_vld), .cpu_irq(cpu_irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference model of the routing rules
  function automatic void ref_map(input int s, input int p, output int idx, output int line);
    if (s == 5) begin idx = p % 4; line = idx + 32; end
    else if (s == 6) begin idx = 4; line = 36; end
    else if (s == 7) begin idx = 5; line = 37; end
    else if (s >= 8 && s <= 12) begin idx = s - 8 + p + 6; line = idx + 32; end
    else begin idx = p; line = p; end
  endfunction

  task automatic send(input int s, input int p, input string tag);
    exp_t e;
    int idx, line;
    ref_map(s, p, idx, line);
    e.line = line;
    e.tag  = tag;
    if (edge_cfg[idx]) begin
      e.now = 1'b1;
    end else begin
      held  = pol_cfg[idx];
      e.now = held;
    end
    e.after = held;
    sb.push_back(e);
    @(negedge clk);
    evt_valid = 1'b1; evt_slot = 5'(s); evt_pin = 2'(p);
    @(negedge clk);
    evt_valid = 1'b0;
    @(negedge clk);
  endtask

  // monitor: compares results as they appear
  always @(negedge clk) begin
    if (rst_n) begin
      if (after_pend) begin
        check({after_tag, " level after"}, int'(cpu_irq), int'(after_val));
        after_pend = 0;
      end
      if (irq_line_vld) begin
        if (sb.size() == 0) begin
          check("R6 unexpected valid", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check({e.tag, " line"}, int'(irq_line), e.line);
          check({e.tag, " irq"}, int'(cpu_irq), int'(e.now));
          after_pend = 1; after_val = e.after; after_tag = e.tag;
        end
      end
    end
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; evt_valid = 1'b0; evt_slot = '0; evt_pin = '0;
    edge_cfg = 32'h0; pol_cfg = 32'h0;
    repeat (3) @(negedge clk);
    check("R1 cpu_irq", int'(cpu_irq), 0);
    check("R1 valid", int'(irq_line_vld), 0);
    check("R1 line", int'(irq_line), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // level mode, alternating polarity across neighbouring indexes
    pol_cfg = 32'h0000_2AAA;
    for (int p = 0; p < 4; p++) send(5, p, "R2 R8 slot5");
    send(6, 0, "R3 slot6 pin0");
    send(6, 3, "R3 slot6 pin3");
    send(7, 1, "R3 slot7 pin1");
    send(7, 2, "R3 slot7 pin2");
    for (int s = 8; s <= 12; s++) send(s, (s * 3) % 4, "R4 R8 swizzle");
    send(12, 3, "R4 top line");
    send(3, 2, "R5 pass slot3");
    send(13, 1, "R5 pass slot13");
    send(0, 0, "R5 pass slot0");

    // edge mode: pulse over a held low level
    edge_cfg = 32'h0000_0030;
    pol_cfg  = 32'h0000_0000;
    send(5, 0, "R8 set low");
    send(6, 2, "R7 R9 pulse over low");
    // pulse over a held high level
    pol_cfg = 32'h0000_0002;
    send(5, 1, "R8 set high");
    send(7, 0, "R7 R9 pulse over high");

    // idle: output keeps the held level while config toggles
    edge_cfg = 32'hFFFF_FFFF;
    pol_cfg  = 32'h0000_0000;
    repeat (6) begin
      @(negedge clk);
      check("R10 idle hold", int'(cpu_irq), 1);
      check("R6 idle no valid", int'(irq_line_vld), 0);
    end

    repeat (3) @(negedge clk);
    check("R6 scoreboard drained", sb.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule